// File: doc/BRIEF.md
# Interprocessor Interrupt and CPU Identity Unit

This unit sits on a shared register bus used by a small cluster of processors. Every request carries the index of the processor that issued it. A read of the identity register returns that index, so each core can learn its own number without any per-core configuration. Two write-one masks manage a pending flag per processor. One mask raises interrupts and the other acknowledges them. Each processor receives its own interrupt line, which is driven straight from its registered pending flag.

Requests arrive on a valid/ready channel. The unit never applies back-pressure: `req_ready` is high whenever the unit is out of reset, so every request with `req_valid` high is accepted on that clock edge. A read produces a one-cycle `rsp_valid` pulse on the edge after it is accepted. A write produces no response. A requester therefore needs no buffering to receive the answer.

The unit also keeps a running count of the interrupts it has raised. Only real transitions of a pending flag from clear to set are counted. The count wraps at its width.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every interrupt line is low, the raised-interrupt count is zero and `rsp_valid` is low.
- R2: A read at byte offset 0 returns the requester's `req_cpu` value, zero-extended, on `rsp_rdata`. `rsp_valid` is high for exactly the one cycle after the accepting edge.
- R3: A read at byte offset 4 returns zero and leaves every interrupt line and the count unchanged.
- R4: A write at byte offset 0 sets the pending flag of processor i for every bit i that is 1 in `req_wdata`. Flags whose bit is 0 keep their value. The new flags appear on `irq` right after the accepting edge.
- R5: A write at byte offset 4 clears the pending flag of processor i for every bit i that is 1 in `req_wdata`. All other flags keep their value. The change appears on `irq` right after the accepting edge.
- R6: Data bits at positions NUM_CPU and above have no effect on any flag or on the count. In particular, writing all ones to offset 0 raises exactly NUM_CPU lines.
- R7: On a write at offset 0, the count increases by the number of flags that change from clear to set. Bits whose flag was already set add nothing.
- R8: `req_ready` is always high out of reset. Writes never produce `rsp_valid`.
- R9: Writes to any byte offset other than 0 and 4 change no flag and do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high out of reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the unit |
| req_wdata | input | DATA_W | Write data (processor mask) |
| req_cpu | input | $clog2(NUM_CPU) | Index of the requesting processor |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | NUM_CPU | Per-processor interrupt lines |
| irq_count | output | CNT_W | Count of interrupts raised |

## Verification
The assertions check on every cycle that a set write leaves every masked line high and a clear write leaves every masked line low. They also check that reads and writes to other offsets leave the lines stable, that the count moves only on a set write, and that a read is always answered on the next edge with the requester's index. Some behaviour can only be shown by the bench's full sweep of every pair of set and clear masks: exact count increments for overlapping masks, the masking of bits above the processor count, and the zero answer at offset 4.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned OFS_RAISE = 0;
  localparam int unsigned OFS_ACK   = 4;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_RAISE = 2'd2,
    ACC_ACK   = 2'd3
  } acc_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode import ipi_pkg::*; #(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned CPU_W  = $clog2(NUM_CPU)
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic [NUM_CPU-1:0] raise_mask,
  output logic [NUM_CPU-1:0] ack_mask,
  output logic              rd_fire,
  output logic [DATA_W-1:0] rd_data
);
  acc_e kind;
  logic [NUM_CPU-1:0] cpu_bits;

  // only the low NUM_CPU data bits name real processors
  assign cpu_bits = req_wdata[NUM_CPU-1:0];

  generate
    if (DATA_W > NUM_CPU) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^req_wdata[DATA_W-1:NUM_CPU];
    end
  endgenerate

  always_comb begin
    kind = ACC_NONE;
    if (req_valid) begin
      if (!req_write) begin
        kind = ACC_READ;
      end else if (req_addr == ADDR_W'(OFS_RAISE)) begin
        kind = ACC_RAISE;
      end else if (req_addr == ADDR_W'(OFS_ACK)) begin
        kind = ACC_ACK;
      end
    end
  end

  assign raise_mask = (kind == ACC_RAISE) ? cpu_bits : '0;
  assign ack_mask   = (kind == ACC_ACK)   ? cpu_bits : '0;
  assign rd_fire    = (kind == ACC_READ);

  always_comb begin
    rd_data = '0;
    if (req_addr == ADDR_W'(OFS_RAISE)) begin
      rd_data = DATA_W'(req_cpu);
    end
  end
endmodule

// File: rtl/ipi_pending.sv
module ipi_pending #(
  parameter int unsigned NUM_CPU = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] raise_mask,
  input  logic [NUM_CPU-1:0] ack_mask,
  output logic [NUM_CPU-1:0] pending
);
  generate
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pending[i] <= 1'b0;
        end else if (raise_mask[i]) begin
          pending[i] <= 1'b1;   // raise dominates acknowledge
        end else if (ack_mask[i]) begin
          pending[i] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ipi_counter.sv
module ipi_counter #(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CPU-1:0] raise_mask,
  input  logic [NUM_CPU-1:0] pending,
  output logic [CNT_W-1:0]   count
);
  logic [NUM_CPU-1:0] fresh;
  logic [CNT_W-1:0]   incr;

  assign fresh = raise_mask & ~pending;

  always_comb begin
    incr = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      incr = incr + CNT_W'(fresh[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count + incr;
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit #(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  input  logic [$clog2(NUM_CPU)-1:0]  req_cpu,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [NUM_CPU-1:0]          irq,
  output logic [CNT_W-1:0]            irq_count
);
  logic [NUM_CPU-1:0] raise_mask;
  logic [NUM_CPU-1:0] ack_mask;
  logic               rd_fire;
  logic [DATA_W-1:0]  rd_data;
  logic [NUM_CPU-1:0] pending;

  assign req_ready = rst_n;

  ipi_decode #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_cpu   (req_cpu),
    .raise_mask(raise_mask),
    .ack_mask  (ack_mask),
    .rd_fire   (rd_fire),
    .rd_data   (rd_data)
  );

  ipi_pending #(.NUM_CPU(NUM_CPU)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_mask(raise_mask),
    .ack_mask  (ack_mask),
    .pending   (pending)
  );

  ipi_counter #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_mask(raise_mask),
    .pending   (pending),
    .count     (irq_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_rdata <= rd_data;
      end
    end
  end

  assign irq = pending;
endmodule

// File: rtl/ipi_unit_checker.sv
module ipi_unit_checker #(
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned CNT_W   = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [DATA_W-1:0]          req_wdata,
  input logic [$clog2(NUM_CPU)-1:0] req_cpu,
  input logic                       rsp_valid,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic [NUM_CPU-1:0]         irq,
  input logic [CNT_W-1:0]           irq_count
);
  logic wr_raise, wr_ack, rd_id, rd_any;
  logic [NUM_CPU-1:0] mask;

  assign rd_any   = req_valid && !req_write;
  assign rd_id    = rd_any && (req_addr == ADDR_W'(0));
  assign wr_raise = req_valid && req_write && (req_addr == ADDR_W'(0));
  assign wr_ack   = req_valid && req_write && (req_addr == ADDR_W'(4));
  assign mask     = req_wdata[NUM_CPU-1:0];

  p_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |=> (rsp_valid && rsp_rdata == DATA_W'($past(req_cpu))));

  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rsp_valid);

  p_no_rsp_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rsp_valid);

  p_read_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any || !req_valid) |=> ($stable(irq) && $stable(irq_count)));

  p_raise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_raise |=> ((irq & $past(mask)) == $past(mask)));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((irq & $past(mask)) == '0));

  p_count_only_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_raise |=> $stable(irq_count));

  p_other_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !wr_raise && !wr_ack) |=> $stable(irq));
endmodule

bind ipi_unit ipi_unit_checker #(
  .NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq),
  .irq_count(irq_count)
);

// File: tb/ipi_unit_bench.sv
module ipi_unit_bench;
  localparam int unsigned NC = 4;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;
  localparam int unsigned CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_cpu = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [NC-1:0] irq;
  logic [CW-1:0] irq_count;

  int checks = 0;
  int fails = 0;
  logic [NC-1:0] m_pend = '0;
  logic [CW-1:0] m_cnt = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipi_unit #(.NUM_CPU(NC), .DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u_ipi_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_cpu(req_cpu), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq(irq), .irq_count(irq_count)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one accepted transfer; returns at the next falling edge, after the
  // accepting rising edge, where registered outputs are already updated
  task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] cpu);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_cpu = cpu;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  function automatic int pop(logic [NC-1:0] v);
    int n = 0;
    for (int i = 0; i < NC; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic raise(logic [DW-1:0] d);
    logic [NC-1:0] b = d[NC-1:0];
    access(1'b1, 3'd0, d, 2'd0);
    m_cnt  = m_cnt + CW'(pop(b & ~m_pend));
    m_pend = m_pend | b;
  endtask

  task automatic ack(logic [DW-1:0] d);
    access(1'b1, 3'd4, d, 2'd0);
    m_pend = m_pend & ~d[NC-1:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 count", 64'(irq_count), 64'h0);
    check("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready", 64'(req_ready), 64'h1);

    // R2 / R3: identity reads for every requester, offset 4 reads
    for (int c = 0; c < NC; c++) begin
      access(1'b0, 3'd0, '0, 2'(c));
      check("R2 rsp_valid", 64'(rsp_valid), 64'h1);
      check("R2 cpu id", 64'(rsp_rdata), 64'(c));
      @(negedge clk);
      check("R2 single pulse", 64'(rsp_valid), 64'h0);
    end
    raise(32'h5);
    check("R4 setup", 64'(irq), 64'(m_pend));
    for (int c = 0; c < NC; c++) begin
      access(1'b0, 3'd4, 32'hF, 2'(c));
      check("R3 read4 zero", 64'(rsp_rdata), 64'h0);
      check("R3 irq unchanged", 64'(irq), 64'(m_pend));
      check("R3 count unchanged", 64'(irq_count), 64'(m_cnt));
    end

    // R9: other offsets ignored
    for (int a = 0; a < 8; a++) begin
      if (a != 0 && a != 4) begin
        access(1'b1, 3'(a), 32'hFFFF_FFFF, 2'd1);
        check("R9 irq", 64'(irq), 64'(m_pend));
        check("R9 count", 64'(irq_count), 64'(m_cnt));
        check("R8 no write rsp", 64'(rsp_valid), 64'h0);
      end
    end

    // R4 R5 R7: all pairs of raise and ack masks
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        ack(32'hF);
        raise(DW'(x));
        check("R4 raise", 64'(irq), 64'(m_pend));
        raise(DW'(y));
        check("R4 raise overlap", 64'(irq), 64'(m_pend));
        check("R7 count", 64'(irq_count), 64'(m_cnt));
        check("R8 no write rsp", 64'(rsp_valid), 64'h0);
        ack(DW'(y ^ 5));
        check("R5 ack", 64'(irq), 64'(m_pend));
      end
    end

    // R6: upper bits have no effect
    ack(32'hF);
    check("R5 all clear", 64'(irq), 64'h0);
    raise(32'hFFFF_FFF0);
    check("R6 upper raise irq", 64'(irq), 64'h0);
    check("R6 upper raise count", 64'(irq_count), 64'(m_cnt));
    raise(32'hFFFF_FFFF);
    check("R6 all ones", 64'(irq), 64'hF);
    check("R6 all ones count", 64'(irq_count), 64'(m_cnt));
    ack(32'hFFFF_FFF0);
    check("R6 upper ack", 64'(irq), 64'hF);

    // R1 again: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset irq", 64'(irq), 64'h0);
    check("R1 reset count", 64'(irq_count), 64'h0);
    check("R8 ready in reset", 64'(req_ready), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule